// File: doc/BRIEF.md
# Consecutive Register Block Loader

This block fills a run of general registers from consecutive memory words. A start pulse brings a starting register number, a 32-bit base value and a signed 16-bit displacement. The block forms the first word address from the base and the displacement. It then reads one word per register over a valid/ready request channel. Each returned word goes straight into a 32-entry register-file write port.

The register number climbs by one and the address by four bytes per word. The walk ends once register 31 has been written, so a start at register k moves 32 − k words. Only one read is in flight at any time. After the final write the block raises `done_o` for a single cycle and then returns to idle, where it accepts the next start.

Top module: `lmw_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `mem_req_valid_o`, `rf_we_o` and `done_o` are all 0.
- R2: The first request address equals `base_i` plus `offset_i` sign-extended from bit 15, using 32-bit wrap-around arithmetic.
- R3: Each later request address is the previous request address plus 4.
- R4: The first write targets register `first_idx_i`, and each later write targets the previous register number plus one.
- R5: A run started at register k performs exactly 32 − k writes, and the last of them targets register 31. A start at 31 gives one write and a start at 0 gives 32.
- R6: A request stays valid with an unchanged address until `mem_req_ready_i` accepts it. No new request is raised until the response to the accepted one has arrived.
- R7: `rf_we_o` is high exactly in a cycle where a response is owed and `mem_rsp_valid_i` is high, and `rf_wdata_o` then equals `mem_rsp_data_i`. `mem_rsp_valid_i` at any other time writes nothing.
- R8: `done_o` is high for exactly one cycle, the cycle after the final write, with `busy_o` still high. `busy_o` is 0 in the following cycle.
- R9: A start pulse while `busy_o` is high is ignored: the run in progress keeps its addresses, registers and word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| first_idx_i | input | 5 | First register to load |
| base_i | input | 32 | Base register value |
| offset_i | input | 16 | Signed displacement |
| busy_o | output | 1 | High from the cycle after a taken start through the done cycle |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_addr_o | output | 32 | Read byte address |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest cases to reach from the ports are a start pulse that lands in the middle of a run and a response-valid strobe that arrives while no read is owed. The bench's memory responder holds `mem_req_ready_i` low for random spells and delays each response by 0 to 2 cycles. In cycles where no read is owed, it drives stray response strobes carrying a marker word. One run is hit with a second start carrying different operands. The reference model then requires the original address sequence, register sequence and word count to continue unchanged.

// File: rtl/lmw_pkg.sv
package lmw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } lmw_state_t;

endpackage

// File: rtl/lmw_addr_gen.sv
module lmw_addr_gen #(
  parameter int AW         = 32,
  parameter int OFF_W      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] base_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [AW-1:0] addr_o
);

  function automatic logic [AW-1:0] first_ea(input logic [AW-1:0] b,
                                             input logic [OFF_W-1:0] o);
    return b + {{(AW-OFF_W){o[OFF_W-1]}}, o};
  endfunction

  function automatic logic [AW-1:0] next_ea(input logic [AW-1:0] a);
    return a + AW'(WORD_BYTES);
  endfunction

  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (load_i)  addr_q <= first_ea(base_i, off_i);
    else if (step_i)  addr_q <= next_ea(addr_q);
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/lmw_idx_ctr.sv
module lmw_idx_ctr #(
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             inc_i,
  input  logic [IDX_W-1:0] first_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
    return i + 1'b1;
  endfunction

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      idx_q <= '0;
    else if (load_i) idx_q <= first_i;
    else if (inc_i)  idx_q <= bump(idx_q);
  end

  assign idx_o  = idx_q;
  assign last_o = (idx_q == TOP_IDX);

endmodule

// File: rtl/lmw_fsm.sv
module lmw_fsm
  import lmw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       req_ready_i,
  input  logic       rsp_valid_i,
  input  logic       last_i,
  output lmw_state_t state_o,
  output logic       start_take_o,
  output logic       req_valid_o,
  output logic       req_fire_o,
  output logic       wr_fire_o,
  output logic       busy_o,
  output logic       done_o
);

  lmw_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i)     st_d = ST_REQ;
      ST_REQ:  if (req_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (rsp_valid_i) st_d = last_i ? ST_DONE : ST_REQ;
      ST_DONE:                  st_d = ST_IDLE;
      default:                  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state_o      = st_q;
  assign start_take_o = (st_q == ST_IDLE) && start_i;
  assign req_valid_o  = (st_q == ST_REQ);
  assign req_fire_o   = (st_q == ST_REQ) && req_ready_i;
  assign wr_fire_o    = (st_q == ST_WAIT) && rsp_valid_i;
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_DONE);

endmodule

// File: rtl/lmw_seq.sv
module lmw_seq
  import lmw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int OFF_W      = 16,
  parameter int NREG       = 32,
  parameter int WORD_BYTES = DW / 8,
  localparam int IDX_W     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] first_idx_i,
  input  logic [AW-1:0]    base_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic             busy_o,
  output logic             mem_req_valid_o,
  output logic [AW-1:0]    mem_req_addr_o,
  input  logic             mem_req_ready_i,
  input  logic             mem_rsp_valid_i,
  input  logic [DW-1:0]    mem_rsp_data_i,
  output logic             rf_we_o,
  output logic [IDX_W-1:0] rf_waddr_o,
  output logic [DW-1:0]    rf_wdata_o,
  output logic             done_o
);

  // named internal events, observed by the bound checker
  lmw_state_t       state;
  logic             start_take;
  logic             req_fire;
  logic             wr_fire;
  logic             last_word;
  logic             advance;
  logic [IDX_W-1:0] idx_cur;

  assign advance = wr_fire && !last_word;

  lmw_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .req_ready_i  (mem_req_ready_i),
    .rsp_valid_i  (mem_rsp_valid_i),
    .last_i       (last_word),
    .state_o      (state),
    .start_take_o (start_take),
    .req_valid_o  (mem_req_valid_o),
    .req_fire_o   (req_fire),
    .wr_fire_o    (wr_fire),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  lmw_addr_gen #(
    .AW         (AW),
    .OFF_W      (OFF_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start_take),
    .step_i (advance),
    .base_i (base_i),
    .off_i  (offset_i),
    .addr_o (mem_req_addr_o)
  );

  lmw_idx_ctr #(
    .NREG  (NREG),
    .IDX_W (IDX_W)
  ) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (start_take),
    .inc_i   (advance),
    .first_i (first_idx_i),
    .idx_o   (idx_cur),
    .last_o  (last_word)
  );

  assign rf_we_o    = wr_fire;
  assign rf_waddr_o = idx_cur;
  assign rf_wdata_o = mem_rsp_data_i;

endmodule

// File: rtl/lmw_seq_chk.sv
module lmw_seq_chk #(
  parameter int AW    = 32,
  parameter int NREG  = 32,
  parameter int IDX_W = $clog2(NREG)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             mem_req_valid_o,
  input logic [AW-1:0]    mem_req_addr_o,
  input logic             mem_req_ready_i,
  input logic             rf_we_o,
  input logic [IDX_W-1:0] rf_waddr_o,
  input logic             done_o,
  input logic             req_fire,
  input logic             wr_fire,
  input logic [IDX_W-1:0] idx_cur
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !mem_req_valid_o);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o && (rf_waddr_o != TOP_IDX) |=> mem_req_addr_o == $past(mem_req_addr_o) + AW'(4));

  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && (rf_waddr_o != TOP_IDX) |=> idx_cur == $past(rf_waddr_o) + 1'b1);

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o && (rf_waddr_o == TOP_IDX) |=> done_o && busy_o);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && !busy_o);

  a_r7_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> busy_o && !mem_req_valid_o);

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && busy_o && !done_o |=> busy_o);

endmodule

bind lmw_seq lmw_seq_chk #(.AW(AW), .NREG(NREG), .IDX_W(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_i         (start_i),
  .busy_o          (busy_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_req_ready_i (mem_req_ready_i),
  .rf_we_o         (rf_we_o),
  .rf_waddr_o      (rf_waddr_o),
  .done_o          (done_o),
  .req_fire        (req_fire),
  .wr_fire         (wr_fire),
  .idx_cur         (idx_cur)
);

// File: tb/sim_lmw_seq.sv
`timescale 1ns/1ps
module sim_lmw_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [4:0]  first_idx_i;
  logic [31:0] base_i;
  logic [15:0] offset_i;
  logic        busy_o;
  logic        mem_req_valid_o;
  logic [31:0] mem_req_addr_o;
  logic        mem_req_ready_i;
  logic        mem_rsp_valid_i;
  logic [31:0] mem_rsp_data_i;
  logic        rf_we_o;
  logic [4:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic        done_o;

  always #2.5 clk = ~clk;

  lmw_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_idx_i(first_idx_i),
    .base_i(base_i), .offset_i(offset_i), .busy_o(busy_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_ready_i(mem_req_ready_i), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .done_o(done_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0F0F;
  endfunction

  // reference model state
  bit          pend = 0;
  logic [31:0] pend_addr = '0;
  logic [31:0] hs_addr = '0;
  int          dly = 0;
  bit          hs_seen = 0;
  bit          model_busy = 0;
  bit          done_exp = 0;
  bit          run_done = 1;
  bit          stray_en = 0;
  int          wr_count = 0;
  int          run_first = 0;
  int          exp_idx[$];
  logic [31:0] exp_addr[$];

  // memory responder: drives just after each rising edge
  initial begin
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = '0;
    forever begin
      @(posedge clk);
      #1;
      if (pend && mem_rsp_valid_i) pend = 0;
      if (hs_seen) begin
        pend = 1;
        pend_addr = hs_addr;
        dly = int'($urandom % 3);
      end
      if (pend) begin
        if (dly > 0) begin
          dly--;
          mem_rsp_valid_i = 1'b0;
          mem_rsp_data_i  = 32'h0;
        end else begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = mem_word(pend_addr);
        end
      end else begin
        mem_rsp_valid_i = stray_en && (($urandom % 2) == 0);
        mem_rsp_data_i  = 32'hDEAD_BEEF;
      end
      mem_req_ready_i = (($urandom % 3) != 0);
    end
  end

  // cycle-by-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(!busy_o && !mem_req_valid_o && !rf_we_o && !done_o, "R1 reset outputs",
          {28'h0, busy_o, mem_req_valid_o, rf_we_o, done_o}, 32'h0);
    end else begin
      bit nb;
      bit exp_we;
      nb = model_busy;
      chk(busy_o == model_busy, "R8 busy", {31'h0, busy_o}, {31'h0, model_busy});
      if (start_i && !model_busy) begin
        exp_idx.delete();
        exp_addr.delete();
        run_first = int'(first_idx_i);
        for (int k = run_first; k < 32; k++) begin
          exp_idx.push_back(k);
          exp_addr.push_back(base_i + {{16{offset_i[15]}}, offset_i} + 32'(4 * (k - run_first)));
        end
        wr_count = 0;
        run_done = 0;
        nb = 1;
      end
      chk(done_o == done_exp, "R8 done pulse", {31'h0, done_o}, {31'h0, done_exp});
      if (done_o && done_exp) begin
        chk(wr_count == 32 - run_first, "R5 word count", 32'(wr_count), 32'(32 - run_first));
        nb = 0;
        run_done = 1;
      end
      done_exp = 0;
      if (mem_req_valid_o) begin
        chk(!pend, "R6 one outstanding", {31'h0, pend}, 32'h0);
        if (wr_count < exp_addr.size())
          chk(mem_req_addr_o == exp_addr[wr_count], wr_count == 0 ? "R2 first addr" : "R3 addr step",
              mem_req_addr_o, exp_addr[wr_count]);
        else
          chk(0, "R5 extra request", mem_req_addr_o, 32'h0);
      end
      hs_seen = mem_req_valid_o && mem_req_ready_i;
      hs_addr = mem_req_addr_o;
      exp_we = pend && mem_rsp_valid_i;
      chk(rf_we_o == exp_we, "R7 write strobe", {31'h0, rf_we_o}, {31'h0, exp_we});
      if (rf_we_o && exp_we) begin
        if (wr_count < exp_idx.size()) begin
          chk(int'(rf_waddr_o) == exp_idx[wr_count], "R4 reg index",
              {27'h0, rf_waddr_o}, 32'(exp_idx[wr_count]));
          chk(rf_wdata_o == mem_word(pend_addr), "R7 write data", rf_wdata_o, mem_word(pend_addr));
          wr_count++;
          if (wr_count == exp_idx.size()) begin
            chk(rf_waddr_o == 5'd31, "R5 last reg", {27'h0, rf_waddr_o}, 32'd31);
            done_exp = 1;
          end
        end else begin
          chk(0, "R5 extra write", {27'h0, rf_waddr_o}, 32'h0);
        end
      end
      model_busy = nb;
    end
  end

  task automatic run_load(input logic [4:0] f, input logic [31:0] b, input logic [15:0] o,
                          input bit poke);
    @(posedge clk); #1;
    start_i = 1'b1; first_idx_i = f; base_i = b; offset_i = o;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(posedge clk);
      #1;
      // R9: second start while busy, different operands
      start_i = 1'b1; first_idx_i = 5'd2; base_i = 32'h7000_0000; offset_i = 16'h0100;
      @(negedge clk);
      chk(busy_o, "R9 busy at stray start", {31'h0, busy_o}, 32'h1);
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    while (!run_done) @(posedge clk);
    @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; first_idx_i = '0; base_i = '0; offset_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !mem_req_valid_o && !done_o, "R1 after reset",
        {29'h0, busy_o, mem_req_valid_o, done_o}, 32'h0);
    run_load(5'd29, 32'h2000_0000, 16'h0020, 0);  // R2 R3 R4: three words
    stray_en = 1;                                 // R7 stray strobes from here on
    run_load(5'd31, 32'h1000_0004, 16'h0000, 0);  // R5 single word
    run_load(5'd0,  32'h0000_1000, 16'hFFF0, 0);  // R2 negative offset, R5 32 words
    run_load(5'd16, 32'h0000_0008, 16'h8000, 1);  // R2 wrap, R9 stray start
    run_load(5'd24, 32'hFFFF_FFF0, 16'h0008, 0);  // R3 address wrap
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog done actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule